// File: doc/BRIEF.md
# DDR Channel Traffic Counter Bank

This block watches the command interface between a memory controller and one to four DDR channels and keeps four running counts per channel: read commands, write commands, cycles with any command, and clock cycles spent counting. Each channel has its own register bank. The banks repeat at a fixed address stride on a simple 32-bit register bus that has an address, a write strobe, write data and combinational read data.

Each bank has one control register. It holds a software counting enable, two further enable bits that are only stored, and three one-hot memory-type bits. Software updates the control register with a masked write: the upper half of the write word chooses which of the lower bits change. To measure traffic, software clears the enables, sets the memory type, sets the software enable, and then reads the counters twice. It takes the difference of the two reads, so the counters roll over plainly and never saturate.

Top module: `ddr_traffic_monitor`

## Requirements
- R1: Each control register keeps six bits: bit 0 timer enable, bit 1 software enable, bit 2 LPDDR2/3 type, bit 3 hardware enable, bit 4 LPDDR4 type, bit 5 DDR4 type. Bits 31:6 read back as zero and cannot be set.
- R2: A control write loads bit k (k < 16) from write-data bit k only when write-data bit k+16 is 1. A bit whose mask bit is 0 keeps its value.
- R3: Channel n's registers start at n × STRIDE: control at +0x04, write count at +0x20, read count at +0x24, cycle count at +0x28, access count at +0x2C. With STRIDE 0x14, channel 1 has control at 0x18 and counters at 0x34, 0x38, 0x3C and 0x40. The channels are independent of each other.
- R4: The four counters of a channel change only on clock edges at which its software enable is 1. After the enable is cleared, they hold their values whatever the command strobes do.
- R5: The cycle counter adds one on every enabled edge. The first enabled edge after a disabled edge starts all four counters again from zero, so the cycle count reads N after N enabled edges.
- R6: On an enabled edge, the read count adds one when the read strobe is high and the write count adds one when the write strobe is high. The access count adds one when either strobe is high.
- R7: Counters are CNT_W bits wide (32 by default), are read zero-extended, and wrap modulo 2^CNT_W.
- R8: A read of an address that maps to no register returns zero. Writes to counter addresses change nothing.
- R9: Bits 0, 3, 2, 4 and 5 have no effect on counting. Only bit 1 gates it.
- R10: An active-low reset clears all control registers and counters at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data; bits 31:16 are the write mask for bits 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cmd_rd | input | NUM_CH | Per-channel read-command strobe |
| cmd_wr | input | NUM_CH | Per-channel write-command strobe |

## Verification
Read data is combinational, so the bench samples it 1 ns after it sets the address, always within the low half of the clock. A control write takes effect at the one rising edge it spans, and that edge is not yet counted. The strobes present at each following rising edge are reflected in the counters from just after that edge. The bench drives each strobe pattern for an exact number of edges and reads the counters before the next edge. It adds one cycle to the expected count for the edge that carries a disabling write. It uses a 10-bit counter configuration so that wrap can be reached in about a thousand cycles.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned MASK_LSB   = 16;
   localparam int unsigned CTRL_BITS  = 6;

   // register offsets inside one channel bank
   localparam int unsigned OFS_CTRL   = 'h04;
   localparam int unsigned OFS_WRCNT  = 'h20;
   localparam int unsigned OFS_RDCNT  = 'h24;
   localparam int unsigned OFS_CYCCNT = 'h28;
   localparam int unsigned OFS_ACCCNT = 'h2C;
   localparam int unsigned BANK_SPAN  = 'h30;

   // control bit positions
   localparam int unsigned CB_TIMER   = 0;
   localparam int unsigned CB_SWEN    = 1;
   localparam int unsigned CB_LP23    = 2;
   localparam int unsigned CB_HWEN    = 3;
   localparam int unsigned CB_LP4     = 4;
   localparam int unsigned CB_DDR4    = 5;

   // counter slots
   localparam int unsigned NUM_CNT    = 4;
   localparam int unsigned IX_WR      = 0;
   localparam int unsigned IX_RD      = 1;
   localparam int unsigned IX_CYC     = 2;
   localparam int unsigned IX_ACC     = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_WR,
      SEL_RD,
      SEL_CYC,
      SEL_ACC
   } reg_sel_e;
endpackage

// File: rtl/ddrmon_bank_decode.sv
module ddrmon_bank_decode
   import ddrmon_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned STRIDE = 'h14,
   parameter int unsigned CH     = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH * STRIDE);

   logic              in_bank;
   logic [ADDR_W-1:0] ofs;

   generate
      if (CH == 0) begin : g_first
         assign in_bank = 1'b1;
      end else begin : g_other
         assign in_bank = (addr >= BASE);
      end
   endgenerate

   assign ofs = addr - BASE;

   always_comb begin
      sel = SEL_NONE;
      if (in_bank) begin
         case (ofs)
            ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
            ADDR_W'(OFS_WRCNT):  sel = SEL_WR;
            ADDR_W'(OFS_RDCNT):  sel = SEL_RD;
            ADDR_W'(OFS_CYCCNT): sel = SEL_CYC;
            ADDR_W'(OFS_ACCCNT): sel = SEL_ACC;
            default:             sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/ddrmon_ctrl_reg.sv
module ddrmon_ctrl_reg
   import ddrmon_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic [CTRL_BITS-1:0] wval,
   input  logic [CTRL_BITS-1:0] wmask,
   output logic [CTRL_BITS-1:0] ctrl_q
);
   generate
      for (genvar b = 0; b < CTRL_BITS; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctrl_q[b] <= 1'b0;
            end else if (wr_stb && wmask[b]) begin
               ctrl_q[b] <= wval[b];
            end
         end
      end
   endgenerate

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (wmask == '0)) |=> $stable(ctrl_q)) else $error("mask hold"); // R2
   AST_MASK_SET_SWEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wmask[CB_SWEN] && wval[CB_SWEN]) |=> ctrl_q[CB_SWEN]) else $error("mask set"); // R2
   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(ctrl_q)) else $error("ctrl moved without write"); // R1
endmodule

// File: rtl/ddrmon_counter_set.sv
module ddrmon_counter_set
   import ddrmon_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rd_stb,
   input  logic             wr_stb,
   output logic [CNT_W-1:0] cnt_wr,
   output logic [CNT_W-1:0] cnt_rd,
   output logic [CNT_W-1:0] cnt_cyc,
   output logic [CNT_W-1:0] cnt_acc
);
   logic               en_q;
   logic               start;
   logic [NUM_CNT-1:0] inc;
   logic [CNT_W-1:0]   cnt [NUM_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   assign start       = en & ~en_q;
   assign inc[IX_WR]  = wr_stb;
   assign inc[IX_RD]  = rd_stb;
   assign inc[IX_CYC] = 1'b1;
   assign inc[IX_ACC] = rd_stb | wr_stb;

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt[k] <= '0;
            end else if (en) begin
               cnt[k] <= (start ? '0 : cnt[k]) + CNT_W'(inc[k]);
            end
         end
      end
   endgenerate

   assign cnt_wr  = cnt[IX_WR];
   assign cnt_rd  = cnt[IX_RD];
   assign cnt_cyc = cnt[IX_CYC];
   assign cnt_acc = cnt[IX_ACC];

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(cnt_wr) && $stable(cnt_rd) && $stable(cnt_cyc) && $stable(cnt_acc)))
      else $error("counter moved while disabled"); // R4
   AST_START_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !en_q) |=> (cnt_cyc == CNT_W'(1))) else $error("restart"); // R5
   AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && en_q) |=> (cnt_cyc == $past(cnt_cyc) + CNT_W'(1))) else $error("cycle step"); // R7
   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && en_q) |=> (cnt_acc == $past(cnt_acc) + CNT_W'($past(rd_stb | wr_stb))))
      else $error("access step"); // R6
endmodule

// File: rtl/ddr_traffic_monitor.sv
module ddr_traffic_monitor
   import ddrmon_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned STRIDE = 'h14,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_CH-1:0] cmd_rd,
   input  logic [NUM_CH-1:0] cmd_wr
);
   localparam int unsigned MAP_TOP = (NUM_CH - 1) * STRIDE + BANK_SPAN;

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_nch
         $error("NUM_CH must be 1..4");
      end
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cntw
         $error("CNT_W must be 2..32");
      end
      if ((STRIDE % 4) != 0) begin : g_bad_align
         $error("STRIDE must be word aligned");
      end
      if (NUM_CH > 1 && !(STRIDE >= BANK_SPAN || (STRIDE == 'h14 && NUM_CH <= 2))) begin : g_bad_stride
         $error("STRIDE makes channel banks collide");
      end
      if (MAP_TOP > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [CTRL_BITS-1:0] wval;
   logic [CTRL_BITS-1:0] wmask;
   logic                 unused_wdata_bits;

   assign wval              = bus_wdata[CTRL_BITS-1:0];
   assign wmask             = bus_wdata[MASK_LSB +: CTRL_BITS];
   assign unused_wdata_bits = ^{bus_wdata[MASK_LSB-1:CTRL_BITS], bus_wdata[BUS_W-1:MASK_LSB+CTRL_BITS]};

   reg_sel_e          sel  [NUM_CH];
   logic [31:0]       part [NUM_CH];
   logic [NUM_CH-1:0] hit;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [CTRL_BITS-1:0] ctrl_q;
         logic [CNT_W-1:0]     c_wr, c_rd, c_cyc, c_acc;

         ddrmon_bank_decode #(
            .ADDR_W (ADDR_W),
            .STRIDE (STRIDE),
            .CH     (ch)
         ) u_dec (
            .addr (bus_addr),
            .sel  (sel[ch])
         );

         ddrmon_ctrl_reg u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (bus_we && (sel[ch] == SEL_CTRL)),
            .wval   (wval),
            .wmask  (wmask),
            .ctrl_q (ctrl_q)
         );

         ddrmon_counter_set #(
            .CNT_W (CNT_W)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl_q[CB_SWEN]),
            .rd_stb  (cmd_rd[ch]),
            .wr_stb  (cmd_wr[ch]),
            .cnt_wr  (c_wr),
            .cnt_rd  (c_rd),
            .cnt_cyc (c_cyc),
            .cnt_acc (c_acc)
         );

         assign hit[ch] = (sel[ch] != SEL_NONE);

         always_comb begin
            case (sel[ch])
               SEL_CTRL: part[ch] = 32'(ctrl_q);
               SEL_WR:   part[ch] = 32'(c_wr);
               SEL_RD:   part[ch] = 32'(c_rd);
               SEL_CYC:  part[ch] = 32'(c_cyc);
               SEL_ACC:  part[ch] = 32'(c_acc);
               default:  part[ch] = '0;
            endcase
         end

         AST_COUNTER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && (sel[ch] inside {SEL_WR, SEL_RD, SEL_CYC, SEL_ACC}) && !ctrl_q[CB_SWEN])
            |=> ($stable(c_wr) && $stable(c_rd) && $stable(c_cyc) && $stable(c_acc)))
            else $error("counter write took effect"); // R8
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         bus_rdata = bus_rdata | part[ch];
      end
   end

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)) else $error("address claimed by two banks"); // R3
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (bus_rdata == '0)) else $error("unmapped read not zero"); // R8
endmodule

// File: tb/tb_ddr_traffic_monitor.sv
module tb_ddr_traffic_monitor;
   localparam int CLK_PERIOD = 20;
   localparam int NCH  = 2;
   localparam int STR  = 'h14;
   localparam int AW   = 16;
   localparam int CW   = 10;
   localparam int WRAP = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NCH-1:0] cmd_rd = '0;
   logic [NCH-1:0] cmd_wr = '0;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_traffic_monitor #(
      .NUM_CH (NCH),
      .STRIDE (STR),
      .ADDR_W (AW),
      .CNT_W  (CW)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cmd_rd    (cmd_rd),
      .cmd_wr    (cmd_wr)
   );

   function automatic int a_of(int ch, int ofs);
      return ch * STR + ofs;
   endfunction

   function automatic bit hit(int i, int m);
      return (m != 0) && ((i % m) == 0);
   endfunction

   // read one register: combinational, sampled 1 ns later
   task automatic chk(string req, int addr, logic [31:0] expv);
      logic [31:0] got;
      bus_addr = AW'(addr);
      #1;
      got = bus_rdata;
      checks++;
      if (got !== expv) begin
         fails++;
         $display("FAIL %s addr=0x%0h actual=0x%0h expected=0x%0h", req, addr, got, expv);
      end
   endtask

   // one bus write spanning exactly one rising edge; called in the low phase
   task automatic wr(int addr, logic [31:0] d);
      bus_addr  = AW'(addr);
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_wdata = '0;
   endtask

   // n rising edges with strobes on both channels
   task automatic run(int n, int rdm, int wrm);
      for (int i = 0; i < n; i++) begin
         cmd_rd = {NCH{hit(i, rdm)}};
         cmd_wr = {NCH{hit(i, wrm)}};
         @(negedge clk);
      end
      cmd_rd = '0;
      cmd_wr = '0;
   endtask

   task automatic check_bank(string req, int ch, int e_wr, int e_rd, int e_cyc, int e_acc);
      chk(req, a_of(ch, 'h20), 32'(e_wr));
      chk(req, a_of(ch, 'h24), 32'(e_rd));
      chk(req, a_of(ch, 'h28), 32'(e_cyc));
      chk(req, a_of(ch, 'h2C), 32'(e_acc));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int e_rd, e_wr, e_acc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10", a_of(0, 'h04), 32'h0);
      chk("R10", a_of(1, 'h04), 32'h0);
      check_bank("R10", 0, 0, 0, 0, 0);
      @(negedge clk);

      // R8 unmapped reads
      chk("R8", 'h00, 32'h0);
      chk("R8", 'h08, 32'h0);
      chk("R8", 'h1C, 32'h0);
      chk("R8", 'h44, 32'h0);
      chk("R8", 'h100, 32'h0);
      @(negedge clk);

      // R1/R2 masked control writes (no counting yet)
      wr(a_of(0, 'h04), 32'h0025_0025);
      chk("R1", a_of(0, 'h04), 32'h25);
      wr(a_of(0, 'h04), 32'h0000_FFFF);
      chk("R2", a_of(0, 'h04), 32'h25);
      wr(a_of(0, 'h04), 32'hFFC0_FFFF);
      chk("R1", a_of(0, 'h04), 32'h25);
      wr(a_of(0, 'h04), 32'h0004_0000);
      chk("R2", a_of(0, 'h04), 32'h21);
      chk("R3", a_of(1, 'h04), 32'h0);
      chk("R4", a_of(0, 'h28), 32'h0);

      // R6/R9: enable with timer and DDR4 bits also set
      wr(a_of(0, 'h04), 32'h0002_0002);
      chk("R9", a_of(0, 'h04), 32'h23);
      @(negedge clk);
      // the edge above counted once with no strobes; start afresh
      wr(a_of(0, 'h04), 32'h0002_0000);
      wr(a_of(0, 'h04), 32'h0002_0002);
      run(60, 3, 4);
      e_rd = 0; e_wr = 0; e_acc = 0;
      for (int i = 0; i < 60; i++) begin
         e_rd  += int'(hit(i, 3));
         e_wr  += int'(hit(i, 4));
         e_acc += int'(hit(i, 3) || hit(i, 4));
      end
      check_bank("R6", 0, e_wr, e_rd, 60, e_acc);
      check_bank("R3", 1, 0, 0, 0, 0);
      @(negedge clk);
      // that extra edge was enabled with no strobes
      chk("R5", a_of(0, 'h28), 32'd61);

      // R4 disable, then strobes must not count
      wr(a_of(0, 'h04), 32'h0002_0000);
      run(40, 1, 1);
      check_bank("R4", 0, e_wr, e_rd, 62, e_acc);
      wr(a_of(0, 'h20), 32'hFFFF_FFFF);
      chk("R8", a_of(0, 'h20), 32'(e_wr));

      // R5 restart from zero
      wr(a_of(0, 'h04), 32'h0002_0002);
      run(5, 1, 0);
      check_bank("R5", 0, 0, 5, 5, 5);
      @(negedge clk);
      wr(a_of(0, 'h04), 32'h0002_0000);

      // R3 channel 1 at the 0x14 stride
      wr(a_of(1, 'h04), 32'h0012_0012);
      chk("R3", 'h18, 32'h12);
      run(7, 0, 1);
      chk("R3", 'h34, 32'd7);
      chk("R3", 'h38, 32'd0);
      chk("R3", 'h3C, 32'd7);
      chk("R3", 'h40, 32'd7);
      @(negedge clk);
      wr(a_of(1, 'h04), 32'h0002_0000);

      // R7 wrap past all-ones
      wr(a_of(0, 'h04), 32'h0002_0002);
      run(1030, 1, 2);
      check_bank("R7", 0, 515 % WRAP, 1030 % WRAP, 1030 % WRAP, 1030 % WRAP);
      @(negedge clk);

      // R10 reset in mid run
      rst_n = 1'b0;
      chk("R10", a_of(0, 'h04), 32'h0);
      chk("R10", a_of(0, 'h28), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", a_of(0, 'h28), 32'h0);

      finish_run();
   end
endmodule